// File: doc/BRIEF.md
# Linear Sensor Readout Sequencer

This block is the digital control core of a linear photosensor array with `NUM_PIX` pixels (64 by default). It issues the strobes that the analog front end needs. One strobe clears every integration capacitor and one sets them to the offset level. A level shows that integration is running. There is one hold/track control per pixel, a one-hot pixel output switch vector, a select for the odd or even readout bus, and a source select that chooses between the temperature channel and the pixel bus for the analog output.

A run starts on a rising clock edge that samples the start input high. It lasts `NUM_PIX + 2` cycles. The first cycle and the last cycle put the temperature channel on the output. The cycles between them step through the pixels one at a time, in ascending or descending index order. After each pixel has been read, its track-and-hold stage returns to track mode. If the start input is still high in the last cycle, the next run follows with no gap. Otherwise the block goes idle. A one-cycle cascade pulse in the last cycle can drive the start input of a following sensor in a chain.

Top module: `lineSensorSeq`

## Requirements
- R1: While `rstN` is low, every output is 0: `holdMask`, `pixSel`, `busOdd`, `srcPixel`, `dischargeEn`, `prechargeEn`, `integrateEn` and `cascadeOut`.
- R2: From idle, a rising edge that samples `startIn` = 1 begins run cycle 1. A run then occupies exactly `NUM_PIX + 2` consecutive cycles.
- R3: In run cycle 1, `dischargeEn` = 1, every bit of `holdMask` is 1 (1 = hold, 0 = track), and `srcPixel` = 0 (0 = temperature channel).
- R4: In run cycle 2, `prechargeEn` = 1. `integrateEn` is 1 from cycle 2 and stays 1 until the next cycle 1, including while idle. It is 0 in cycle 1.
- R5: In run cycles 2 to `NUM_PIX + 1`, `srcPixel` = 1 and `pixSel` has exactly one bit set. That bit advances one pixel per cycle in scan order. In all other cycles, `pixSel` is 0.
- R6: A pixel selected in cycle k stays in hold until cycle k and enters track (its `holdMask` bit goes to 0) from cycle k + 1 for the rest of the run.
- R7: With `dirDown` = 0, the scan runs from pixel 0 upward. With `dirDown` = 1, it runs from pixel `NUM_PIX - 1` downward. `dirDown` is sampled only on the edge that begins cycle 1 and has no effect for the rest of that run.
- R8: `busOdd` equals bit 0 of the selected pixel index while a pixel is selected, and is 0 otherwise.
- R9: In the last run cycle, `srcPixel` = 0 and `cascadeOut` = 1. `cascadeOut` is 0 in every other cycle.
- R10: If `startIn` = 1 on the edge that ends the last cycle, the next cycle is cycle 1 of a new run. If `startIn` = 0, the block goes idle. `startIn` has no effect during cycles 1 to `NUM_PIX + 1`.
- R11: While idle, `srcPixel` = 0, `pixSel` = 0, and `dischargeEn` = `prechargeEn` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset (low-supply detect) |
| startIn | input | 1 | Start request, sampled on rising edges |
| dirDown | input | 1 | Scan direction: 0 ascending, 1 descending |
| dischargeEn | output | 1 | Clear all integration capacitors (cycle 1) |
| prechargeEn | output | 1 | Set capacitors to the offset level (cycle 2) |
| integrateEn | output | 1 | Integration in progress |
| srcPixel | output | 1 | Output source: 1 pixel bus, 0 temperature channel |
| cascadeOut | output | 1 | One-cycle pulse in the last run cycle |
| busOdd | output | 1 | Readout bus select: 1 odd line, 0 even line |
| pixSel | output | NUM_PIX | One-hot pixel output switches |
| holdMask | output | NUM_PIX | Per-pixel hold (1) / track (0) control |

## Verification
The bench builds the block with `NUM_PIX` = 7, so a run is nine cycles long. Every cycle of every run can therefore be compared against arithmetic expectations for all ports. Because the pixel count is odd, a descending scan starts on an even pixel. This exercises the parity start of the bus select in both directions. The short run also lets the bench reach back-to-back restarts, a mid-run change of direction and start, and a reset in the middle of a run within a few dozen cycles.

// File: rtl/lineSensorPkg.sv
package lineSensorPkg;

  // Strobes passed from the run controller to the pixel datapath.
  typedef struct packed {
    logic runStart;   // next cycle is run cycle 1
    logic loadFirst;  // next cycle selects the first pixel
    logic shiftStep;  // next cycle selects the following pixel
    logic scanDown;   // direction latched for this run
  } seqStrobeT;

endpackage

// File: rtl/lineSensorCtrl.sv
module lineSensorCtrl
  import lineSensorPkg::*;
#(
  parameter int NUM_PIX = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startIn,
  input  logic      dirDown,
  output seqStrobeT strobe,
  output logic      dischargeEn,
  output logic      prechargeEn,
  output logic      integrateEn,
  output logic      srcPixel,
  output logic      cascadeOut
);
  localparam int RUN_LEN = NUM_PIX + 2;
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] CYC_FIRST = CW'(1);
  localparam logic [CW-1:0] CYC_PIX0 = CW'(2);
  localparam logic [CW-1:0] CYC_PREV_LAST_PIX = CW'(NUM_PIX);
  localparam logic [CW-1:0] CYC_LAST_PIX = CW'(NUM_PIX + 1);
  localparam logic [CW-1:0] CYC_LAST = CW'(RUN_LEN);

  logic [CW-1:0] cyc;      // 0 = idle, else run cycle number
  logic          scanDown;
  logic          inRun;
  logic          runStart;

  assign inRun    = (cyc != '0);
  assign runStart = startIn && (!inRun || cyc == CYC_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cyc         <= '0;
      scanDown    <= 1'b0;
      integrateEn <= 1'b0;
    end else begin
      if (runStart) begin
        cyc      <= CYC_FIRST;
        scanDown <= dirDown;
      end else if (cyc == CYC_LAST) begin
        cyc <= '0;
      end else if (inRun) begin
        cyc <= cyc + 1'b1;
      end
      if (runStart) begin
        integrateEn <= 1'b0;
      end else if (cyc == CYC_FIRST) begin
        integrateEn <= 1'b1;
      end
    end
  end

  assign dischargeEn = (cyc == CYC_FIRST);
  assign prechargeEn = (cyc == CYC_PIX0);
  assign srcPixel    = (cyc >= CYC_PIX0) && (cyc <= CYC_LAST_PIX);
  assign cascadeOut  = (cyc == CYC_LAST);

  assign strobe.runStart  = runStart;
  assign strobe.loadFirst = (cyc == CYC_FIRST);
  assign strobe.shiftStep = (cyc >= CYC_PIX0) && (cyc <= CYC_PREV_LAST_PIX);
  assign strobe.scanDown  = scanDown;

endmodule

// File: rtl/lineSensorPath.sv
module lineSensorPath
  import lineSensorPkg::*;
#(
  parameter int NUM_PIX = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobeT          strobe,
  output logic [NUM_PIX-1:0] pixSel,
  output logic [NUM_PIX-1:0] holdMask,
  output logic               busOdd
);
  localparam logic [NUM_PIX-1:0] LOW_END = NUM_PIX'(1);
  localparam logic [NUM_PIX-1:0] HIGH_END = LOW_END << (NUM_PIX - 1);
  localparam logic TOP_ODD = ((NUM_PIX - 1) % 2) == 1;

  logic [NUM_PIX-1:0] nextSel;
  logic               nextOdd;

  always_comb begin
    nextSel = '0;
    nextOdd = 1'b0;
    if (strobe.loadFirst) begin
      nextSel = strobe.scanDown ? HIGH_END : LOW_END;
      nextOdd = strobe.scanDown ? TOP_ODD : 1'b0;
    end else if (strobe.shiftStep) begin
      nextSel = strobe.scanDown ? (pixSel >> 1) : (pixSel << 1);
      nextOdd = ~busOdd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixSel <= '0;
      busOdd <= 1'b0;
    end else begin
      pixSel <= nextSel;
      busOdd <= nextOdd;
    end
  end

  // One hold/track cell per pixel: hold on run start, track after its read slot.
  for (genvar i = 0; i < NUM_PIX; i++) begin : g_hold
    logic cellHold;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cellHold <= 1'b0;
      end else if (strobe.runStart) begin
        cellHold <= 1'b1;
      end else if (pixSel[i]) begin
        cellHold <= 1'b0;
      end
    end
    assign holdMask[i] = cellHold;
  end

endmodule

// File: rtl/lineSensorSeq.sv
module lineSensorSeq
  import lineSensorPkg::*;
#(
  parameter int NUM_PIX = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startIn,
  input  logic               dirDown,
  output logic               dischargeEn,
  output logic               prechargeEn,
  output logic               integrateEn,
  output logic               srcPixel,
  output logic               cascadeOut,
  output logic               busOdd,
  output logic [NUM_PIX-1:0] pixSel,
  output logic [NUM_PIX-1:0] holdMask
);
  seqStrobeT strobe;

  lineSensorCtrl #(.NUM_PIX(NUM_PIX)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startIn    (startIn),
    .dirDown    (dirDown),
    .strobe     (strobe),
    .dischargeEn(dischargeEn),
    .prechargeEn(prechargeEn),
    .integrateEn(integrateEn),
    .srcPixel   (srcPixel),
    .cascadeOut (cascadeOut)
  );

  lineSensorPath #(.NUM_PIX(NUM_PIX)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .pixSel  (pixSel),
    .holdMask(holdMask),
    .busOdd  (busOdd)
  );

endmodule

// File: rtl/lineSensorChk.sv
module lineSensorChk #(
  parameter int NUM_PIX = 64
) (
  input logic               clk,
  input logic               rstN,
  input logic               dischargeEn,
  input logic               prechargeEn,
  input logic               integrateEn,
  input logic               srcPixel,
  input logic               cascadeOut,
  input logic               busOdd,
  input logic [NUM_PIX-1:0] pixSel,
  input logic [NUM_PIX-1:0] holdMask
);

  p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pixSel));

  p_sel_matches_src_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|pixSel) == srcPixel);

  p_discharge_all_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    dischargeEn |-> (&holdMask && !srcPixel && !integrateEn));

  p_precharge_after_discharge_r4: assert property (@(posedge clk) disable iff (!rstN)
    dischargeEn |=> (prechargeEn && integrateEn));

  p_selected_is_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    srcPixel |-> |(pixSel & holdMask));

  p_read_pixel_tracks_r6: assert property (@(posedge clk) disable iff (!rstN)
    srcPixel |=> ((holdMask & $past(pixSel)) == '0));

  p_bus_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !srcPixel |-> !busOdd);

  p_bus_alternates_r8: assert property (@(posedge clk) disable iff (!rstN)
    (srcPixel && $past(srcPixel)) |-> (busOdd != $past(busOdd)));

  p_cascade_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    cascadeOut |=> !cascadeOut);

  p_cascade_temp_r9: assert property (@(posedge clk) disable iff (!rstN)
    cascadeOut |-> !srcPixel);

endmodule

bind lineSensorSeq lineSensorChk #(.NUM_PIX(NUM_PIX)) u_chk (.*);

// File: tb/test_lineSensorSeq.sv
module test_lineSensorSeq;
  localparam int N = 7;
  localparam int RUN = N + 2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startIn = 1'b0;
  logic         dirDown = 1'b0;
  logic         dischargeEn, prechargeEn, integrateEn, srcPixel, cascadeOut, busOdd;
  logic [N-1:0] pixSel, holdMask;

  int checks = 0;
  int failures = 0;

  // Reference state, derived from the requirements.
  int mCyc = 0;
  bit mDir = 1'b0;
  bit mInt = 1'b0;

  always #5 clk = ~clk;

  lineSensorSeq #(.NUM_PIX(N)) i_lineSensorSeq (
    .clk(clk), .rstN(rstN), .startIn(startIn), .dirDown(dirDown),
    .dischargeEn(dischargeEn), .prechargeEn(prechargeEn),
    .integrateEn(integrateEn), .srcPixel(srcPixel), .cascadeOut(cascadeOut),
    .busOdd(busOdd), .pixSel(pixSel), .holdMask(holdMask)
  );

  // R2/R10: run begins on a sampled start from idle or from the last cycle.
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCyc = 0;
      mDir = 1'b0;
      mInt = 1'b0;
    end else if (startIn && (mCyc == 0 || mCyc == RUN)) begin
      mCyc = 1;
      mDir = dirDown;
      mInt = 1'b0;
    end else begin
      if (mCyc == 1) mInt = 1'b1;
      if (mCyc == RUN) mCyc = 0;
      else if (mCyc != 0) mCyc = mCyc + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [N-1:0] eSel, eHold;
    bit ePix, eOdd;
    int idx;
    eSel = '0; eHold = '0; eOdd = 1'b0;
    ePix = (mCyc >= 2) && (mCyc <= N + 1);
    if (ePix) begin
      idx = mDir ? (N - 1 - (mCyc - 2)) : (mCyc - 2);
      eSel[idx] = 1'b1;
      eOdd = idx[0];
    end
    for (int i = 0; i < N; i++) begin
      int pos = mDir ? (N - 1 - i) : i;
      eHold[i] = (mCyc != 0) && (mCyc <= pos + 2);
    end
    chk("R5/R7 pixSel", 64'(pixSel), 64'(eSel));
    chk("R3/R6 holdMask", 64'(holdMask), 64'(eHold));
    chk("R8 busOdd", 64'(busOdd), 64'(eOdd));
    chk("R5/R11 srcPixel", 64'(srcPixel), 64'(ePix));
    chk("R3 dischargeEn", 64'(dischargeEn), 64'(mCyc == 1));
    chk("R4 prechargeEn", 64'(prechargeEn), 64'(mCyc == 2));
    chk("R4 integrateEn", 64'(integrateEn), 64'(mInt));
    chk("R9 cascadeOut", 64'(cascadeOut), 64'(mCyc == RUN));
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  initial begin
    #(3000 * 10);
    failures++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int gap;
    // R1: reset state
    step(2);
    chk("R1 reset outputs", 64'({dischargeEn, prechargeEn, integrateEn, srcPixel,
        cascadeOut, busOdd, |pixSel, |holdMask}), 64'(0));
    rstN = 1'b1;
    step(2);

    // R2: single start pulse, ascending scan, then idle (R11)
    startIn = 1'b1; dirDown = 1'b0;
    step(1);
    chk("R2 run cycle 1 entered", 64'(dischargeEn), 64'(1));
    startIn = 1'b0;
    gap = 1;
    while (!cascadeOut && gap < 40) begin
      step(1);
      gap++;
    end
    chk("R2 run length", 64'(gap), 64'(RUN));
    step(3);

    // R7: descending, direction changed mid-run; R10: mid-run start ignored
    startIn = 1'b1; dirDown = 1'b1;
    step(1);
    startIn = 1'b0;
    step(2);
    dirDown = 1'b0;
    step(2);
    startIn = 1'b1;
    step(1);
    startIn = 1'b0;
    step(RUN + 2);
    chk("R10 idle after run", 64'(srcPixel | dischargeEn), 64'(0));

    // R10: continuous runs, direction switched between runs
    startIn = 1'b1; dirDown = 1'b0;
    step(RUN);
    chk("R10 last cycle of first run", 64'(cascadeOut), 64'(1));
    dirDown = 1'b1;
    step(1);
    chk("R10 back-to-back restart", 64'(dischargeEn), 64'(1));
    step(RUN - 1);
    startIn = 1'b0;
    step(RUN + 3);

    // R1: reset in the middle of a run
    startIn = 1'b1; dirDown = 1'b0;
    step(1);
    startIn = 1'b0;
    step(4);
    rstN = 1'b0;
    #1;
    chk("R1 mid-run reset", 64'({srcPixel, |pixSel, |holdMask, integrateEn}), 64'(0));
    compareAll();
    step(2);
    rstN = 1'b1;
    step(3);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule